// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Controller

This block keeps a DRAM's contents alive. Once reset is released it holds the strobes idle for a power-up pause. It then runs a fixed burst of refresh cycles on its own and raises an init-done flag. From then on an interval timer adds one owed refresh every refresh period. While any refresh is owed, the block asks the access sequencer for the bus. Once the bus is granted, it works off the owed refreshes back to back. It then lowers its request, and the sequencer may take the bus back.

The default refresh is CAS-before-RAS. CAS goes low before RAS, and the write strobe stays high, so the DRAM uses its internal row counter and no address is needed. A mode input selects RAS-only refresh instead. In that mode CAS stays high, and the block presents a row from its own counter, which advances after every such cycle. All timing limits are set as clock-cycle counts by parameters: pause, set-up, hold, RAS low time, precharge and refresh interval.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: During and straight after reset, ras_n, cas_n and we_n are high, ref_req is low and init_done is low.
- R2: No RAS falling edge occurs before PWRUP_CYC clock cycles have passed since reset was released.
- R3: Exactly INIT_REFRESHES refresh cycles run before init_done rises. They need no grant, ref_req stays low throughout, and init_done then stays high.
- R4: In a CAS-before-RAS cycle, cas_n is low for at least CSR_CYC cycles before ras_n falls and stays low for at least CHR_CYC cycles after ras_n falls.
- R5: we_n is high at every RAS falling edge, and at all other times.
- R6: ras_n stays low for at least RAS_CYC cycles. It stays high for at least max(RP_CYC, RPC_CYC) cycles between cycles, and for at least RPC_CYC cycles between ras_n rising and the next cas_n fall.
- R7: The first ref_req after init_done rises REFI_CYC to REFI_CYC+2 cycles after init_done. One refresh is then owed every REFI_CYC cycles, whether or not grant is present.
- R8: After M refresh intervals without grant, a grant yields exactly min(M, MAX_OWED) refresh cycles.
- R9: Once raised, ref_req stays high until grant is given.
- R10: ref_req falls only once the precharge of the last owed refresh is complete, with ras_n high for at least the precharge length at that moment.
- R11: After init_done, no RAS falling edge occurs while ref_gnt is low.
- R12: When ras_only is high at the start of a refresh cycle, cas_n stays high for the whole cycle.
- R13: In RAS-only cycles, row_addr is stable while ras_n is low. It increases by one, modulo 2^ROW_W, from each RAS-only cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_only | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS; sampled when each cycle starts |
| ref_gnt | input | 1 | Bus grant from the access sequencer |
| ref_req | output | 1 | Refresh request to the access sequencer |
| init_done | output | 1 | High once the power-up pause and initial burst are complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| row_addr | output | ROW_W | Row presented in RAS-only refresh |

## Verification
The grant is withheld for a random number of refresh intervals, from one to six, measured from the rising edge of the request. The number of refresh cycles in the following grant then shows two things: whether owed refreshes are counted correctly, and whether the count saturates at the limit above four. Rounds in CAS-before-RAS mode are mixed with rounds in RAS-only mode. In the RAS-only rounds the absence of any CAS fall is observed and row continuity is followed across the counter wrap; the CAS-before-RAS rounds check set-up and hold. Every RAS edge is also measured for pulse width and precharge. The power-up phase is checked for pause length and for the number of initial cycles.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SETUP, SQ_HOLD, SQ_ACT, SQ_PRE
  } sq_state_t;

  typedef enum logic [1:0] {
    PH_PWRUP, PH_INIT, PH_RUN
  } phase_t;
endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
  parameter int PERIOD = 1950
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(PERIOD - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/dref_owed_counter.sv
module dref_owed_counter #(
  parameter int MAX_OWED = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic pending
);
  localparam int OW = $clog2(MAX_OWED + 1);
  logic [OW-1:0] owed, owed_n;

  always_comb begin
    owed_n = owed;
    if (inc && !dec) begin
      if (owed != OW'(MAX_OWED)) owed_n = owed + 1'b1;
    end else if (dec && !inc) begin
      if (owed != '0) owed_n = owed - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owed    <= '0;
      pending <= 1'b0;
    end else begin
      owed    <= owed_n;
      pending <= (owed_n != '0);
    end
  end
endmodule

// File: rtl/dref_strobe_seq.sv
module dref_strobe_seq
  import dref_pkg::*;
#(
  parameter int CSR_CYC = 1,
  parameter int CHR_CYC = 2,
  parameter int RAS_CYC = 7,
  parameter int RP_CYC  = 4,
  parameter int RPC_CYC = 1,
  parameter int ROW_W   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             ras_only,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row,
  output logic             busy,
  output logic             done
);
  localparam int SETUP_LEN = CSR_CYC;
  localparam int HOLD_LEN  = CHR_CYC;
  localparam int ACT_LEN   = (RAS_CYC > CHR_CYC) ? RAS_CYC - CHR_CYC : 1;
  localparam int PRE_LEN   = (RP_CYC > RPC_CYC) ? RP_CYC : RPC_CYC;
  localparam int M1        = (SETUP_LEN > HOLD_LEN) ? SETUP_LEN : HOLD_LEN;
  localparam int M2        = (ACT_LEN > PRE_LEN) ? ACT_LEN : PRE_LEN;
  localparam int MAXLEN    = (M1 > M2) ? M1 : M2;
  localparam int CW        = $clog2(MAXLEN + 1);

  sq_state_t     st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          cbr_q, cbr_n;
  logic          done_n;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    cbr_n  = cbr_q;
    done_n = 1'b0;
    case (st)
      SQ_IDLE: if (start) begin
        st_n  = SQ_SETUP;
        cnt_n = CW'(SETUP_LEN - 1);
        cbr_n = !ras_only;
      end
      SQ_SETUP: if (cnt == '0) begin
        st_n  = SQ_HOLD;
        cnt_n = CW'(HOLD_LEN - 1);
      end else cnt_n = cnt - 1'b1;
      SQ_HOLD: if (cnt == '0) begin
        st_n  = SQ_ACT;
        cnt_n = CW'(ACT_LEN - 1);
      end else cnt_n = cnt - 1'b1;
      SQ_ACT: if (cnt == '0) begin
        st_n  = SQ_PRE;
        cnt_n = CW'(PRE_LEN - 1);
      end else cnt_n = cnt - 1'b1;
      SQ_PRE: if (cnt == '0) begin
        st_n   = SQ_IDLE;
        done_n = 1'b1;
      end else cnt_n = cnt - 1'b1;
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SQ_IDLE;
      cnt   <= '0;
      cbr_q <= 1'b1;
      done  <= 1'b0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      row   <= '0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      cbr_q <= cbr_n;
      done  <= done_n;
      ras_n <= !(st_n == SQ_HOLD || st_n == SQ_ACT);
      cas_n <= !(cbr_n && (st_n == SQ_SETUP || st_n == SQ_HOLD));
      we_n  <= 1'b1;
      if (done_n && !cbr_q) row <= row + 1'b1;
    end
  end

  assign busy = (st != SQ_IDLE) || done;
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dref_pkg::*;
#(
  parameter int PWRUP_CYC      = 25000,
  parameter int INIT_REFRESHES = 8,
  parameter int REFI_CYC       = 1950,
  parameter int MAX_OWED       = 4,
  parameter int CSR_CYC        = 1,
  parameter int CHR_CYC        = 2,
  parameter int RAS_CYC        = 7,
  parameter int RP_CYC         = 4,
  parameter int RPC_CYC        = 1,
  parameter int ROW_W          = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ras_only,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             init_done,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr
);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam int IW = $clog2(INIT_REFRESHES + 1);

  phase_t        phase;
  logic [PW-1:0] pwr_cnt;
  logic [IW-1:0] init_cnt;
  logic          busy, done, tick, start;

  assign start = !busy &&
                 ((phase == PH_INIT && init_cnt != IW'(INIT_REFRESHES)) ||
                  (phase == PH_RUN && ref_gnt && ref_req));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_PWRUP;
      pwr_cnt   <= '0;
      init_cnt  <= '0;
      init_done <= 1'b0;
    end else begin
      case (phase)
        PH_PWRUP: begin
          if (pwr_cnt == PW'(PWRUP_CYC - 1)) phase <= PH_INIT;
          else pwr_cnt <= pwr_cnt + 1'b1;
        end
        PH_INIT: if (done) begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == IW'(INIT_REFRESHES - 1)) begin
            phase     <= PH_RUN;
            init_done <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  dref_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
    .clk(clk), .rst(rst), .en(phase == PH_RUN), .tick(tick)
  );

  dref_owed_counter #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk(clk), .rst(rst), .inc(tick),
    .dec(done && phase == PH_RUN), .pending(ref_req)
  );

  dref_strobe_seq #(
    .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC),
    .RP_CYC(RP_CYC), .RPC_CYC(RPC_CYC), .ROW_W(ROW_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .ras_only(ras_only),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row(row_addr),
    .busy(busy), .done(done)
  );
endmodule

// File: rtl/dref_checker.sv
module dref_checker #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic             init_done,
  input logic             ras_n,
  input logic             cas_n,
  input logic [ROW_W-1:0] row_addr
);
  a_r3_no_req_before_init: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !ref_req);
  a_r3_init_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) && !cas_n |-> $past(!cas_n));
  a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
    ref_req && !ref_gnt |=> ref_req);
  a_r10_req_drops_in_precharge: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_req) |-> ras_n && $past(ras_n));
  a_r11_quiet_without_grant: assert property (@(posedge clk) disable iff (rst)
    init_done && !ref_gnt && ras_n && cas_n |=> ras_n && cas_n);
  a_r13_row_stable: assert property (@(posedge clk) disable iff (rst)
    !ras_n && $past(!ras_n) |-> $stable(row_addr));
endmodule

bind dram_refresh_ctrl dref_checker #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr)
);

// File: tb/tb_dram_refresh_ctrl.sv
module tb_dram_refresh_ctrl;
  localparam int PWRUP = 300, NINIT = 8, REFI = 400, MAXO = 4;
  localparam int CSR = 2, CHR = 2, RASC = 5, RP = 3, RPC = 2, RW = 5;
  localparam int PRE = (RP > RPC) ? RP : RPC;

  logic clk = 0, rst = 1, ras_only = 0, gnt = 0;
  logic req, idone, ras_n, cas_n, we_n;
  logic [RW-1:0] row;
  int checks = 0, fails = 0;
  int cyc = 0, init_falls = 0, grant_falls = 0;
  int cas_low_run = 0, ras_low_run = 0, ras_high_run = 0, hold_run = 0;
  int wraps = 0;
  logic cur_cbr = 1, prev_ras = 1, prev_cas = 1, has_row = 0, mon_en = 0;
  logic [RW-1:0] last_row = '0;

  always #4 clk = ~clk;

  dram_refresh_ctrl #(.PWRUP_CYC(PWRUP), .INIT_REFRESHES(NINIT), .REFI_CYC(REFI),
    .MAX_OWED(MAXO), .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RASC), .RP_CYC(RP),
    .RPC_CYC(RPC), .ROW_W(RW)) dut (
    .clk(clk), .rst(rst), .ras_only(ras_only), .ref_gnt(gnt), .ref_req(req),
    .init_done(idone), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_burst(input int m);
    return (m < MAXO) ? m : MAXO;
  endfunction

  function automatic logic [RW-1:0] next_row(input logic [RW-1:0] r);
    return r + 1'b1;
  endfunction

  // port monitor
  always @(negedge clk) if (mon_en) begin
    cyc++;
    if (prev_ras && !ras_n) begin
      cur_cbr = !cas_n;
      if (!idone) init_falls++;
      if (gnt) grant_falls++;
      chk(cyc > PWRUP, "R2 ras fall after pause", cyc, PWRUP);
      chk(we_n, "R5 we_n high at ras fall", we_n, 1);
      chk(!idone || gnt, "R11 ras fall needs grant", gnt, 1);
      if (has_row || init_falls > 1 || idone)
        chk(ras_high_run >= PRE, "R6 precharge length", ras_high_run, PRE);
      if (cur_cbr) chk(cas_low_run >= CSR, "R4 cas setup", cas_low_run, CSR);
      else begin
        if (has_row) begin
          chk(row == next_row(last_row), "R13 row increment", row, next_row(last_row));
          if (row == '0) wraps++;
        end
        has_row = 1;
        last_row = row;
      end
      hold_run = 0;
    end
    if (!prev_ras && ras_n) begin
      chk(ras_low_run >= RASC, "R6 ras low width", ras_low_run, RASC);
      if (cur_cbr) chk(hold_run >= CHR, "R4 cas hold", hold_run, CHR);
    end
    if (prev_cas && !cas_n && ras_n && ras_high_run > 0 && (has_row || init_falls > 0))
      chk(ras_high_run >= RPC, "R6 ras-to-cas precharge", ras_high_run, RPC);
    if (!ras_n && !cur_cbr && !cas_n)
      chk(0, "R12 cas stays high in ras-only", cas_n, 1);
    if (!ras_n && !cas_n) hold_run++;
    cas_low_run  = cas_n ? 0 : cas_low_run + 1;
    ras_low_run  = ras_n ? 0 : ras_low_run + 1;
    ras_high_run = ras_n ? ras_high_run + 1 : 0;
    prev_ras = ras_n;
    prev_cas = cas_n;
  end

  task automatic wait_req(input int limit, output int waited);
    waited = 0;
    while (!req && waited < limit) begin @(negedge clk); waited++; end
  endtask

  task automatic round(input logic mode, input int m);
    int w, falls_exp;
    bit held;
    ras_only = mode;
    wait_req(REFI + 10, w);
    chk(req, "R7 request within one interval", w, REFI);
    held = 1;
    for (int i = 0; i < m * REFI - REFI / 2; i++) begin
      @(negedge clk);
      if (!req) held = 0;
    end
    chk(held, "R9 request held without grant", held, 1);
    grant_falls = 0;
    gnt = 1;
    w = 0;
    while (req && w < 2000) begin @(negedge clk); w++; end
    chk(ras_high_run >= PRE, "R10 req drop after precharge", ras_high_run, PRE);
    falls_exp = exp_burst(m);
    chk(grant_falls == falls_exp, "R8 refreshes per grant", grant_falls, falls_exp);
    gnt = 0;
  endtask

  initial begin
    int w;
    void'($urandom(32'd11));
    repeat (5) @(negedge clk);
    chk(ras_n && cas_n && we_n && !req && !idone, "R1 reset state",
        {ras_n, cas_n, we_n, req, idone}, 5'b11100);
    rst = 0;
    mon_en = 1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && !req && !idone, "R1 state after reset",
        {ras_n, cas_n, we_n, req, idone}, 5'b11100);
    w = 0;
    while (!idone && w < PWRUP + 1000) begin
      @(negedge clk); w++;
      if (req) chk(0, "R3 no request before init_done", req, 0);
    end
    chk(init_falls == NINIT, "R3 initial refresh count", init_falls, NINIT);
    wait_req(REFI + 10, w);
    chk(w >= REFI - 1 && w <= REFI + 3, "R7 first request spacing", w, REFI);
    // directed: one interval, then saturation
    round(1'b0, 1);
    round(1'b0, 6);
    for (int k = 0; k < 6; k++) round(1'b0, 1 + int'($urandom_range(5)));
    round(1'b1, 1);
    round(1'b1, 5);
    for (int k = 0; k < 18; k++) round(1'b1, 1 + int'($urandom_range(5)));
    chk(wraps > 0, "R13 row counter wraps", wraps, 1);
    chk(idone, "R3 init_done stays high", idone, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule